// File: doc/BRIEF.md
# Decoder Power-Down Sequencer

This block runs on the host side of a paging decoder link. It drives the decoder into its asynchronous off state. It asks the packet transport for three control packets in a fixed order: decoder off, decoder on, decoder off. It holds back each request until enough time has passed since the previous packet finished on the wire. The transport reports that point with a one-cycle strobe on the last rising clock edge of each packet. Time is counted in clock cycles (ticks). The parameter `TICKS_2MS` says how many ticks make up 2 ms.

When a start is accepted, the block latches two programmed totals: the receiver shut-down total and the receiver warm-up total. The first gap must reach the larger of 2 ms and the shut-down total, and has no ceiling. The second gap must reach 2 ms and must not pass the warm-up total minus 2 ms. If the warm-up total is below 4 ms, that window is empty. The block then flags an error and issues no packets at all.

The request side is a valid/ready stream. Once `req_valid_o` is high, it stays high, and `req_on_o` stays unchanged, until `req_ready_i` is seen high on a rising edge. That edge is the handshake. The transport may hold `req_ready_i` low for any number of cycles. The request waits, and the stall makes the gap longer, which the first gap and the lower bounds allow. A stall that pushes the third packet past the upper bound ends the run with the error flag set.

Top module: `decoder_off_seq`

## Requirements
- R1: During and after reset, `req_valid_o`, `done_o` and `err_o` are 0.
- R2: A start accepted with a non-empty window raises `req_valid_o` with `req_on_o`=0 in the cycle after the start edge, and clears `done_o` and `err_o`.
- R3: While `req_valid_o` is 1 and `req_ready_i` is 0, the next cycle keeps `req_valid_o`=1 and `req_on_o` unchanged.
- R4: The second request (`req_on_o`=1) first appears in the cycle after the edge that lies max(TICKS_2MS, shut-down total) ticks after the first packet's done edge.
- R5: The third request (`req_on_o`=0) first appears in the cycle after the edge that lies TICKS_2MS ticks after the second packet's done edge.
- R6: If the third done strobe comes at most (warm-up total − TICKS_2MS) ticks after the second done edge, the next cycle shows `done_o`=1 and `err_o`=0.
- R7: If the third done strobe comes later than that bound, the next cycle shows `done_o`=1 and `err_o`=1.
- R8: A start accepted with a warm-up total below 2·TICKS_2MS gives `done_o`=1 and `err_o`=1 in the next cycle, and no request is ever made for that run.
- R9: A start pulse or a change of either total while a sequence is running has no effect; the totals are taken only at the accepted start.
- R10: `done_o` and `err_o` hold until the next accepted start. Starts are accepted only when idle or finished.
- R11: A done strobe that arrives while no sent packet is awaiting completion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the power-down sequence |
| shut_total_i | input | TW | Programmed shut-down total, in ticks |
| warm_total_i | input | TW | Programmed warm-up total, in ticks |
| req_valid_o | output | 1 | Control-packet request valid |
| req_ready_i | input | 1 | Transport accepts the request on this edge |
| req_on_o | output | 1 | Decoder-on value for the requested packet |
| pkt_done_i | input | 1 | One-cycle strobe on the last clock edge of a sent packet |
| done_o | output | 1 | Sequence finished |
| err_o | output | 1 | Sequence failed (empty window or late third packet) |

## Verification
- **Registered outputs (R2, R6, R7, R8).** The start, the final done strobe and the empty-window error each change state at the edge that samples them. Their results show one cycle later.
- **Gap-timed requests (R4, R5).** The second and third requests depend on a counter that resets at the previous done edge. The request appears in the cycle after the edge at which the counter reaches the required gap.
- **How the bench samples.** The bench drives inputs and compares outputs only on falling edges. Its integer model advances on rising edges from the same sampled inputs. Every output is therefore checked in the exact cycle it is due, with no slack in either direction.
- **Ignored stimulus (R9, R11).** Both are observed through request timing and the final flags. The bench applies the disturbance in the middle of a running sequence and keeps comparing on every cycle.

// File: rtl/decoder_off_seq_pkg.sv
package decoder_off_seq_pkg;

  // Sequencer phases: each packet has an issue phase and a completion wait.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_REQ1  = 3'd1,  // off packet requested immediately
    PH_WAIT1 = 3'd2,
    PH_GAP1  = 3'd3,  // on packet requested once first gap met
    PH_WAIT2 = 3'd4,
    PH_GAP2  = 3'd5,  // off packet requested once 2 ms met
    PH_WAIT3 = 3'd6,
    PH_END   = 3'd7
  } phase_t;

  function automatic logic phase_accepts_start(phase_t p);
    return (p == PH_IDLE) || (p == PH_END);
  endfunction

endpackage

// File: rtl/decoder_off_seq_limits.sv
module decoder_off_seq_limits #(
  parameter int unsigned TW        = 24,
  parameter int unsigned TICKS_2MS = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] shut_i,
  input  logic [TW-1:0] warm_i,
  output logic          win_ok_o,
  output logic [TW-1:0] min1_o,
  output logic [TW-1:0] max3_o
);
  localparam int unsigned EW = TW + 2;
  localparam logic [EW-1:0] T2E   = EW'(TICKS_2MS);
  localparam logic [EW-1:0] T4E   = T2E << 1;
  localparam logic [TW-1:0] T2T   = TW'(TICKS_2MS);

  logic [TW-1:0] min1_q, max3_q;
  logic [TW-1:0] min1_d;

  // Window for the last gap is [2 ms, warm - 2 ms]; empty below 4 ms.
  assign win_ok_o = ({2'b00, warm_i} >= T4E);
  assign min1_d   = (shut_i > T2T) ? shut_i : T2T;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min1_q <= '0;
      max3_q <= '0;
    end else if (load_i) begin
      min1_q <= min1_d;
      max3_q <= warm_i - T2T;
    end
  end

  assign min1_o = min1_q;
  assign max3_o = max3_q;
endmodule

// File: rtl/decoder_off_seq_gapcnt.sv
module decoder_off_seq_gapcnt #(
  parameter int unsigned CW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  // Ticks since the last completion edge; saturates rather than wraps.
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/decoder_off_seq_ctrl.sv
module decoder_off_seq_ctrl
  import decoder_off_seq_pkg::*;
#(
  parameter int unsigned TW        = 24,
  parameter int unsigned CW        = TW + 1,
  parameter int unsigned TICKS_2MS = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          win_ok_i,
  input  logic [TW-1:0] min1_i,
  input  logic [TW-1:0] max3_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          req_ready_i,
  input  logic          pkt_done_i,
  output logic          load_o,
  output logic          cnt_clr_o,
  output logic          req_valid_o,
  output logic          req_on_o,
  output logic          done_o,
  output logic          err_o
);
  localparam logic [CW-1:0] T2C = CW'(TICKS_2MS);

  phase_t ph_q, ph_d;
  logic   err_q;
  logic   gap1_met, gap2_met, late3, hs;

  assign gap1_met = (cnt_i >= CW'(min1_i));
  assign gap2_met = (cnt_i >= T2C);
  // cnt holds gap-1 at the sampling edge, so gap > max3 <=> cnt >= max3.
  assign late3    = (cnt_i >= CW'(max3_i));

  assign load_o      = start_i && phase_accepts_start(ph_q);
  assign req_valid_o = (ph_q == PH_REQ1) ||
                       ((ph_q == PH_GAP1) && gap1_met) ||
                       ((ph_q == PH_GAP2) && gap2_met);
  assign req_on_o    = (ph_q == PH_GAP1);
  assign hs          = req_valid_o && req_ready_i;
  assign cnt_clr_o   = pkt_done_i && ((ph_q == PH_WAIT1) || (ph_q == PH_WAIT2));

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE, PH_END: if (load_o) ph_d = win_ok_i ? PH_REQ1 : PH_END;
      PH_REQ1:  if (hs)         ph_d = PH_WAIT1;
      PH_WAIT1: if (pkt_done_i) ph_d = PH_GAP1;
      PH_GAP1:  if (hs)         ph_d = PH_WAIT2;
      PH_WAIT2: if (pkt_done_i) ph_d = PH_GAP2;
      PH_GAP2:  if (hs)         ph_d = PH_WAIT3;
      PH_WAIT3: if (pkt_done_i) ph_d = PH_END;
      default:                  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      err_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (load_o)                                 err_q <= !win_ok_i;
      else if ((ph_q == PH_WAIT3) && pkt_done_i)  err_q <= late3;
    end
  end

  assign done_o = (ph_q == PH_END);
  assign err_o  = err_q;
endmodule

// File: rtl/decoder_off_seq.sv
module decoder_off_seq #(
  parameter int unsigned TW        = 24,
  parameter int unsigned TICKS_2MS = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [TW-1:0] shut_total_i,
  input  logic [TW-1:0] warm_total_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_on_o,
  input  logic          pkt_done_i,
  output logic          done_o,
  output logic          err_o
);
  localparam int unsigned CW = TW + 1;

  logic          load, win_ok, cnt_clr;
  logic [TW-1:0] min1, max3;
  logic [CW-1:0] cnt;

  decoder_off_seq_limits #(.TW(TW), .TICKS_2MS(TICKS_2MS)) u_limits (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .shut_i(shut_total_i), .warm_i(warm_total_i),
    .win_ok_o(win_ok), .min1_o(min1), .max3_o(max3)
  );

  decoder_off_seq_gapcnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .cnt_o(cnt)
  );

  decoder_off_seq_ctrl #(.TW(TW), .CW(CW), .TICKS_2MS(TICKS_2MS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_ok_i(win_ok),
    .min1_i(min1), .max3_i(max3), .cnt_i(cnt),
    .req_ready_i(req_ready_i), .pkt_done_i(pkt_done_i),
    .load_o(load), .cnt_clr_o(cnt_clr),
    .req_valid_o(req_valid_o), .req_on_o(req_on_o),
    .done_o(done_o), .err_o(err_o)
  );
endmodule

// File: rtl/decoder_off_seq_chk.sv
module decoder_off_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic req_valid_o,
  input logic req_ready_i,
  input logic req_on_o,
  input logic done_o,
  input logic err_o
);
  // R3: a stalled request keeps its valid and its on value
  a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_on_o));

  // R7: an error always comes with a finished sequence
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R6: no request once the sequence has finished
  a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);

  // R10: a start from the finished state clears done unless the window is empty
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && start_i |=> !done_o || err_o);

  // R8: an immediate error never pairs with a pending request
  a_r8_no_req_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !req_valid_o);
endmodule

bind decoder_off_seq decoder_off_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_on_o(req_on_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/decoder_off_seq_tb_top.sv
module decoder_off_seq_tb_top;
  localparam int TW = 12;
  localparam int T2 = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [TW-1:0] shut_total_i = '0;
  logic [TW-1:0] warm_total_i = '0;
  logic req_valid_o, req_ready_i, req_on_o, done_o, err_o;
  logic pkt_done_i = 1'b0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  decoder_off_seq #(.TW(TW), .TICKS_2MS(T2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .shut_total_i(shut_total_i), .warm_total_i(warm_total_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_on_o(req_on_o),
    .pkt_done_i(pkt_done_i), .done_o(done_o), .err_o(err_o)
  );

  // ---------------- behavioural reference model ----------------
  bit m_busy, m_sent, m_fin, m_err;
  int m_step, m_el, m_need, m_min1, m_max3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sent = 0; m_fin = 0; m_err = 0;
      m_step = 0; m_el = 0; m_need = 0; m_min1 = 0; m_max3 = 0;
    end else if (!m_busy) begin
      if (start_i) begin
        m_fin = 0; m_err = 0;
        if (int'(warm_total_i) < 2 * T2) begin
          m_fin = 1; m_err = 1;
        end else begin
          m_busy = 1; m_step = 1; m_sent = 0; m_el = 0; m_need = 0;
          m_min1 = (int'(shut_total_i) > T2) ? int'(shut_total_i) : T2;
          m_max3 = int'(warm_total_i) - T2;
        end
      end
    end else begin
      if (!m_sent && m_el >= m_need && req_ready_i) begin
        m_sent = 1; m_el++;
      end else if (m_sent && pkt_done_i) begin
        if (m_step == 3) begin
          m_busy = 0; m_fin = 1; m_err = (m_el >= m_max3);
        end else begin
          m_step++; m_sent = 0; m_el = 0;
          m_need = (m_step == 2) ? m_min1 : T2;
        end
      end else begin
        m_el++;
      end
    end
  end

  function automatic string step_tag(int s);
    if (s == 2) return "R4";
    if (s == 3) return "R5";
    return "R2";
  endfunction

  // ---------------- responder + per-cycle compare ----------------
  bit rdy_rand = 0;
  bit inj_done = 0;
  int lat[1:3] = '{3, 3, 3};
  int hs_cnt = 0;
  int dcount = 0;
  bit prev_stall = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      string tg;
      ev = m_busy && !m_sent && (m_el >= m_need);
      tg = prev_stall ? "R3" : step_tag(m_step);
      checks++;
      if (req_valid_o !== ev) begin
        failures++;
        $display("FAIL %s req_valid actual=%0b expected=%0b t=%0t", tg, req_valid_o, ev, $time);
      end
      if (ev) begin
        checks++;
        if (req_on_o !== (m_step == 2)) begin
          failures++;
          $display("FAIL %s req_on actual=%0b expected=%0b", tg, req_on_o, (m_step == 2));
        end
      end
      checks++;
      if (done_o !== m_fin || err_o !== m_err) begin
        failures++;
        $display("FAIL %s done/err actual=%0b/%0b expected=%0b/%0b",
                 m_err ? "R7" : "R6", done_o, err_o, m_fin, m_err);
      end
      prev_stall = ev && !req_ready_i;
    end
    // drive next-cycle transport inputs
    pkt_done_i = inj_done;
    if (dcount > 0) begin
      dcount--;
      if (dcount == 0) pkt_done_i = 1'b1;
    end
    req_ready_i = rdy_rand ? 1'($urandom_range(0, 1)) : 1'b1;
    if (req_valid_o && req_ready_i && rst_n) begin
      hs_cnt++;
      dcount = lat[(hs_cnt > 3) ? 3 : hs_cnt];
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- directed scenarios ----------------
  task automatic check_eq(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input int shut, input int warm, input int l1, input int l2,
                          input int l3, input bit rr, input bit disturb, input bit chk_clear,
                          input int exp_err, input int exp_hs, input string tag);
    lat[1] = l1; lat[2] = l2; lat[3] = l3;
    rdy_rand = rr;
    @(negedge clk);
    shut_total_i = TW'(shut); warm_total_i = TW'(warm);
    hs_cnt = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (chk_clear) begin
      check_eq("R10", int'(done_o), 0, "done cleared by restart");
      check_eq("R10", int'(err_o), 0, "err cleared by restart");
    end
    if (disturb) begin
      // R9/R11: mid-gap start, new totals and a stray done strobe
      for (int i = 0; i < 200 && hs_cnt < 1; i++) @(negedge clk);
      repeat (l1 + 3) @(negedge clk);
      start_i = 1'b1; inj_done = 1'b1;
      shut_total_i = '0; warm_total_i = TW'(10);
      @(negedge clk);
      start_i = 1'b0; inj_done = 1'b0;
    end
    for (int i = 0; i < 3000 && !done_o; i++) @(negedge clk);
    check_eq(tag, int'(done_o), 1, "done at end");
    check_eq(tag, int'(err_o), exp_err, "err at end");
    check_eq(tag, hs_cnt, exp_hs, "requests issued");
    rdy_rand = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1", int'(req_valid_o), 0, "valid in reset");
    check_eq("R1", int'(done_o), 0, "done in reset");
    check_eq("R1", int'(err_o), 0, "err in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", int'(req_valid_o), 0, "valid after reset");
    // R2 R4 R6: shut-down total below 2 ms, 2 ms dominates
    run_case(5, 100, 3, 3, 3, 0, 0, 0, 0, 3, "R6");
    // R3 R4: shut-down total dominates, random back-pressure
    run_case(50, 200, 2, 2, 2, 1, 0, 0, 0, 3, "R3");
    // R7: third done far beyond the window
    run_case(5, 60, 3, 3, 30, 0, 0, 0, 1, 3, "R7");
    // R7 boundary: gap 23 against limit 22
    run_case(5, 42, 2, 2, 2, 0, 0, 0, 1, 3, "R7");
    // R6 boundary: gap 23 against limit 23
    run_case(5, 43, 2, 2, 2, 0, 0, 0, 0, 3, "R6");
    // R8: window exactly 4 ms is not empty (runs, ends late)
    run_case(5, 40, 1, 1, 1, 0, 0, 0, 1, 3, "R8");
    // R8: window empty, no requests
    run_case(5, 39, 3, 3, 3, 0, 0, 0, 1, 0, "R8");
    // R10: restart from an error clears the flags; R9 R11 disturbances
    run_case(50, 100, 4, 3, 3, 0, 1, 1, 0, 3, "R9");
    // R10: error again, then a clean restart
    run_case(5, 30, 3, 3, 3, 0, 0, 0, 1, 0, "R8");
    run_case(5, 100, 3, 3, 3, 0, 0, 1, 0, 3, "R10");
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule